// File: doc/BRIEF.md
# Dual Data Address Generator

This block produces memory addresses from two banks of index and modify registers. Generator 0 holds index and modify registers 0 to 7 and works on 32-bit addresses. Generator 1 holds registers 8 to 15 and works on 24-bit addresses. Each request selects a generator, an index register, an operation and a modify source. The modify source is either one of that generator's modify registers or a short signed immediate. A request can also carry a condition bit, and a request whose condition is false does nothing.

An access either adds the modify value before issuing the address and leaves the index register alone, or issues the current index value and writes the sum back. Two further operations update an index register without issuing an address: a plain add of a wide immediate, and the same add with the bits of the result reversed. A write port loads any index or modify register.

Top module: `dual_dag`

## Requirements
- R1: `req_gen`=0 selects generator 0: index and modify registers 0-7, 32-bit arithmetic. `req_gen`=1 selects generator 1: registers 8-15, 24-bit arithmetic, with addresses zero-extended on `addr_out`. On the write port, bit 3 of `wr_num` selects the generator and bits 2:0 select the register. Only one generator updates a register per cycle.
- R2: Access (`req_op`=00) with `req_post`=1 issues the current index value I as the address, then sets I to (I + modify) modulo 2^W, where W is the generator width.
- R3: Access with `req_post`=0 issues (I + modify) modulo 2^W and leaves I unchanged.
- R4: With `req_imm_sel`=1, the modify value of an access is `req_imm[5:0]` read as two's complement and sign-extended. With `req_imm_sel`=0, it is modify register `req_mod` of the selected generator.
- R5: Modify (`req_op`=01) sets I to (I + `req_imm`) modulo 2^W, using the low W bits of `req_imm`, and issues no address.
- R6: Bit-reverse (`req_op`=10) sets I to the W-bit bit reversal of (I + `req_imm`) modulo 2^W and issues no address.
- R7: A request with `req_cond`=0, and any request with `req_op`=11, issues no address and changes no register.
- R8: `wr_en` with `wr_kind`=0 loads an index register and with `wr_kind`=1 loads a modify register, taking the low W bits of `wr_data`. The new value is used by requests from the next cycle on.
- R9: If a write and an index update target the same index register in the same cycle, the index update is stored.
- R10: `addr_valid`, `addr_gen` and `addr_out` are registered: they show the result of an access one clock after the request. `addr_valid` is 0 in any cycle that follows no issuing request.
- R11: Reset clears all index and modify registers and `addr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_cond | input | 1 | Condition result; 0 cancels the request |
| req_gen | input | 1 | Generator select |
| req_op | input | 2 | 00 access, 01 modify, 10 bit-reverse modify, 11 none |
| req_post | input | 1 | 1 post-modify with write-back, 0 pre-modify |
| req_imm_sel | input | 1 | Access uses the short immediate instead of a modify register |
| req_idx | input | 3 | Index register within the generator |
| req_mod | input | 3 | Modify register within the generator |
| req_imm | input | 32 | Immediate (bits 5:0 for access, full width for modify) |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 1 | 0 index, 1 modify |
| wr_num | input | 4 | Register number 0-15 |
| wr_data | input | 32 | Write data |
| addr_valid | output | 1 | Address issued |
| addr_gen | output | 1 | Generator of the issued address |
| addr_out | output | 32 | Issued address |

## Verification
The bench sweeps every index register against every modify register in both modes. After each access it reads the index register back, so it catches a pre-modify that writes back or a post-modify that issues the sum. It walks all 64 short immediates, which catches a design that zero-extends them or misplaces the sign bit. It runs wide immediates on both generators that carry past bit 23 or bit 31, which catches missing wrap or masking on the 24-bit side, and it checks the bit reversal over the generator's own width. It also checks that cancelled requests leave both the address port and the registers untouched, and it drives a write and an update to the same register in one cycle to confirm which value is kept.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    OP_ACCESS = 2'b00,
    OP_MODIFY = 2'b01,
    OP_BITREV = 2'b10,
    OP_NONE   = 2'b11
  } dag_op_e;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i_en,
  input  logic                    wr_m_en,
  input  logic [$clog2(NREG)-1:0] wr_num,
  input  logic [W-1:0]            wr_data,
  input  logic                    wb_en,
  input  logic [$clog2(NREG)-1:0] wb_num,
  input  logic [W-1:0]            wb_data,
  input  logic [$clog2(NREG)-1:0] rd_i_num,
  input  logic [$clog2(NREG)-1:0] rd_m_num,
  output logic [W-1:0]            rd_i,
  output logic [W-1:0]            rd_m
);
  localparam int NW = $clog2(NREG);

  logic [W-1:0] i_q [NREG];
  logic [W-1:0] m_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    logic         i_wr_hit, i_wb_hit, i_ce, m_ce;
    logic [W-1:0] i_d;

    // next state: write-back beats the write port
    always_comb begin
      i_wr_hit = wr_i_en && (wr_num == NW'(k));
      i_wb_hit = wb_en && (wb_num == NW'(k));
      i_ce     = i_wr_hit || i_wb_hit;
      i_d      = i_wb_hit ? wb_data : wr_data;
      m_ce     = wr_m_en && (wr_num == NW'(k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    i_q[k] <= '0;
      else if (i_ce) i_q[k] <= i_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_q[k] <= '0;
      else if (m_ce) m_q[k] <= wr_data;
    end
  end

  assign rd_i = i_q[rd_i_num];
  assign rd_m = m_q[rd_m_num];
endmodule

// File: rtl/dag_calc.sv
module dag_calc
  import dag_pkg::*;
#(
  parameter int W    = 32,
  parameter int SIMM = 6
) (
  input  logic         go,
  input  dag_op_e      op,
  input  logic         post,
  input  logic         imm_sel,
  input  logic [W-1:0] ival,
  input  logic [W-1:0] mval,
  input  logic [W-1:0] imm,
  output logic         issue,
  output logic [W-1:0] addr,
  output logic         wb_en,
  output logic [W-1:0] wb_data
);
  logic [W-1:0] short_ext, mod_v, sum, rev;

  always_comb begin
    short_ext = {{(W-SIMM){imm[SIMM-1]}}, imm[SIMM-1:0]};
    if (op == OP_ACCESS) mod_v = imm_sel ? short_ext : mval;
    else                 mod_v = imm;
    sum = ival + mod_v;
    for (int b = 0; b < W; b++) rev[b] = sum[W-1-b];

    issue   = go && (op == OP_ACCESS);
    addr    = post ? ival : sum;
    wb_en   = go && (((op == OP_ACCESS) && post) || (op == OP_MODIFY) || (op == OP_BITREV));
    wb_data = (op == OP_BITREV) ? rev : sum;
  end
endmodule

// File: rtl/dag_unit.sv
module dag_unit
  import dag_pkg::*;
#(
  parameter int W    = 32,
  parameter int OW   = 32,
  parameter int NREG = 8,
  parameter int SIMM = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  dag_op_e                 op,
  input  logic                    post,
  input  logic                    imm_sel,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [$clog2(NREG)-1:0] mod,
  input  logic [W-1:0]            imm,
  input  logic                    wr_i_en,
  input  logic                    wr_m_en,
  input  logic [$clog2(NREG)-1:0] wr_num,
  input  logic [W-1:0]            wr_data,
  output logic                    issue,
  output logic                    wb_en,
  output logic [OW-1:0]           addr_o
);
  logic [W-1:0] ival, mval, addr_w, wb_data;

  dag_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_i_en(wr_i_en), .wr_m_en(wr_m_en), .wr_num(wr_num), .wr_data(wr_data),
    .wb_en(wb_en), .wb_num(idx), .wb_data(wb_data),
    .rd_i_num(idx), .rd_m_num(mod), .rd_i(ival), .rd_m(mval)
  );

  dag_calc #(.W(W), .SIMM(SIMM)) u_calc (
    .go(go), .op(op), .post(post), .imm_sel(imm_sel),
    .ival(ival), .mval(mval), .imm(imm),
    .issue(issue), .addr(addr_w), .wb_en(wb_en), .wb_data(wb_data)
  );

  always_comb begin
    addr_o         = '0;
    addr_o[W-1:0]  = addr_w;
  end
endmodule

// File: rtl/dual_dag.sv
module dual_dag
  import dag_pkg::*;
#(
  parameter int AW0  = 32,
  parameter int AW1  = 24,
  parameter int NREG = 8,
  parameter int SIMM = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_cond,
  input  logic                    req_gen,
  input  logic [1:0]              req_op,
  input  logic                    req_post,
  input  logic                    req_imm_sel,
  input  logic [$clog2(NREG)-1:0] req_idx,
  input  logic [$clog2(NREG)-1:0] req_mod,
  input  logic [AW0-1:0]          req_imm,
  input  logic                    wr_en,
  input  logic                    wr_kind,
  input  logic [$clog2(NREG):0]   wr_num,
  input  logic [AW0-1:0]          wr_data,
  output logic                    addr_valid,
  output logic                    addr_gen,
  output logic [AW0-1:0]          addr_out
);
  localparam int NW = $clog2(NREG);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dag_op_e         op_e;
  logic [1:0]      u_issue, u_wb;
  logic [AW0-1:0]  u_addr [2];

  assign op_e = dag_op_e'(req_op);

  for (genvar g = 0; g < 2; g++) begin : g_gen
    localparam int W = (g == 0) ? AW0 : AW1;
    logic go, wi, wm;
    always_comb begin
      go = req_valid && req_cond && (req_gen == 1'(g));
      wi = wr_en && !wr_kind && (wr_num[NW] == 1'(g));
      wm = wr_en &&  wr_kind && (wr_num[NW] == 1'(g));
    end

    dag_unit #(.W(W), .OW(AW0), .NREG(NREG), .SIMM(SIMM)) u_unit (
      .clk(clk), .rst_n(rst_sync_n), .go(go), .op(op_e), .post(req_post),
      .imm_sel(req_imm_sel), .idx(req_idx), .mod(req_mod), .imm(req_imm[W-1:0]),
      .wr_i_en(wi), .wr_m_en(wm), .wr_num(wr_num[NW-1:0]), .wr_data(wr_data[W-1:0]),
      .issue(u_issue[g]), .wb_en(u_wb[g]), .addr_o(u_addr[g])
    );
  end

  // output stage: next state
  logic           av_n, ag_n;
  logic [AW0-1:0] ad_n;
  always_comb begin
    av_n = |u_issue;
    ag_n = u_issue[1];
    if (u_issue[1])      ad_n = u_addr[1];
    else if (u_issue[0]) ad_n = u_addr[0];
    else                 ad_n = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_valid <= 1'b0;
      addr_gen   <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= av_n;
      addr_gen   <= ag_n;
      addr_out   <= ad_n;
    end
  end
endmodule

// File: rtl/dual_dag_chk.sv
module dual_dag_chk #(
  parameter int AW0 = 32,
  parameter int AW1 = 24
) (
  input logic           clk,
  input logic           rst_ok,
  input logic           req_valid,
  input logic           req_cond,
  input logic           req_gen,
  input logic [1:0]     req_op,
  input logic           req_post,
  input logic           addr_valid,
  input logic           addr_gen,
  input logic [AW0-1:0] addr_out,
  input logic [1:0]     wb_en
);
  logic armed;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_ISSUE_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_ok)
    armed |-> (addr_valid == $past(req_valid && req_cond && (req_op == 2'b00)))); // R10
  AST_GEN1_ADDR_WIDTH: assert property (@(posedge clk) disable iff (!rst_ok)
    (addr_valid && addr_gen) |-> ((addr_out >> AW1) == '0)); // R1
  AST_ONE_GEN_UPDATES: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(wb_en)); // R1
  AST_UPDATE_SIDE: assert property (@(posedge clk) disable iff (!rst_ok)
    wb_en[1] |-> req_gen); // R1
  AST_FALSE_COND_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !req_cond) |-> (wb_en == 2'b00)); // R7
  AST_PRE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_cond && (req_op == 2'b00) && !req_post) |-> (wb_en == 2'b00)); // R3
endmodule

bind dual_dag dual_dag_chk #(.AW0(AW0), .AW1(AW1)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .req_valid(req_valid), .req_cond(req_cond),
  .req_gen(req_gen), .req_op(req_op), .req_post(req_post),
  .addr_valid(addr_valid), .addr_gen(addr_gen), .addr_out(addr_out), .wb_en(u_wb)
);

// File: tb/dual_dag_test.sv
`timescale 1ns/1ps
module dual_dag_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_cond, req_gen, req_post, req_imm_sel;
  logic [1:0]  req_op;
  logic [2:0]  req_idx, req_mod;
  logic [31:0] req_imm;
  logic        wr_en, wr_kind;
  logic [3:0]  wr_num;
  logic [31:0] wr_data;
  logic        addr_valid, addr_gen;
  logic [31:0] addr_out;

  always #2.5 clk = ~clk;

  dual_dag uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cond(req_cond),
    .req_gen(req_gen), .req_op(req_op), .req_post(req_post), .req_imm_sel(req_imm_sel),
    .req_idx(req_idx), .req_mod(req_mod), .req_imm(req_imm),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_num(wr_num), .wr_data(wr_data),
    .addr_valid(addr_valid), .addr_gen(addr_gen), .addr_out(addr_out)
  );

  int nchk = 0, nfail = 0;
  logic [31:0] mi [16];
  logic [31:0] mm [16];

  function automatic logic [31:0] msk(input int g);
    return (g == 0) ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
  endfunction
  function automatic logic [31:0] brev(input logic [31:0] v, input int g);
    logic [31:0] r = '0;
    int w = (g == 0) ? 32 : 24;
    for (int b = 0; b < w; b++) r[b] = v[w-1-b];
    return r;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_cond = 0; req_gen = 0; req_op = 0; req_post = 0;
    req_imm_sel = 0; req_idx = 0; req_mod = 0; req_imm = 0;
    wr_en = 0; wr_kind = 0; wr_num = 0; wr_data = 0;
  endtask

  task automatic wr(input logic kind, input int n, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = kind; wr_num = 4'(n); wr_data = d;
    @(posedge clk); #1;
    idle();
    if (kind) mm[n] = d & msk(n / 8);
    else      mi[n] = d & msk(n / 8);
  endtask

  // issue a request, update the model, check the address port
  task automatic req(input string rq, input int g, input logic [1:0] opc, input logic post,
                     input logic isel, input int idx, input int md, input logic [31:0] imm,
                     input logic cond);
    int n = g * 8 + idx;
    logic [31:0] iv = mi[n], mv, sum, ea;
    logic ev;
    if (opc == 2'b00) mv = isel ? {{26{imm[5]}}, imm[5:0]} : mm[g * 8 + md];
    else              mv = imm;
    sum = (iv + mv) & msk(g);
    ev  = cond && (opc == 2'b00);
    ea  = post ? iv : sum;
    @(negedge clk);
    req_valid = 1; req_cond = cond; req_gen = 1'(g); req_op = opc; req_post = post;
    req_imm_sel = isel; req_idx = 3'(idx); req_mod = 3'(md); req_imm = imm;
    @(posedge clk); #1;
    chk({rq, " valid"}, {31'b0, addr_valid}, {31'b0, ev});
    if (ev) begin
      chk({rq, " addr"}, addr_out, ea);
      chk({rq, " gen"}, {31'b0, addr_gen}, 32'(g));
    end
    idle();
    if (cond) begin
      if (opc == 2'b00 && post) mi[n] = sum;
      if (opc == 2'b01)         mi[n] = sum;
      if (opc == 2'b10)         mi[n] = brev(sum, g);
    end
  endtask

  task automatic rdi(input string rq, input int n);
    logic [31:0] e = mi[n];
    @(negedge clk);
    req_valid = 1; req_cond = 1; req_gen = 1'(n / 8); req_op = 2'b00; req_post = 1;
    req_imm_sel = 1; req_idx = 3'(n % 8); req_imm = 0;
    @(posedge clk); #1;
    chk({rq, " readback"}, addr_out, e);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    for (int k = 0; k < 16; k++) begin mi[k] = 0; mm[k] = 0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1 chk("R11 reset valid", {31'b0, addr_valid}, 32'd0);
    for (int k = 0; k < 16; k++) rdi("R11 reset I", k);
    req("R11 reset M", 0, 2'b00, 0, 0, 0, 5, 0, 1);

    // load registers; generator 1 values exercise masking (R8, R1)
    for (int k = 0; k < 16; k++) begin
      wr(0, k, 32'hFFFF_FFF0 + 32'(k * 3));
      wr(1, k, (k % 2 == 1) ? (32'd0 - 32'(k + 1)) : 32'(k * 5 + 1));
    end
    for (int k = 0; k < 16; k++) rdi("R8 R1 load", k);

    // register modify sweep, both modes (R2, R3)
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 8; i++)
        for (int m = 0; m < 8; m++)
          for (int p = 0; p < 2; p++) begin
            req(p ? "R2 post reg" : "R3 pre reg", g, 2'b00, 1'(p), 0, i, m, 0, 1);
            rdi(p ? "R2 post update" : "R3 pre no update", g * 8 + i);
          end

    // every short immediate (R4)
    for (int g = 0; g < 2; g++)
      for (int v = 0; v < 64; v++) begin
        req("R4 short imm", g, 2'b00, 1'(v % 2), 1, v % 8, 0, 32'h0000_FFC0 | 32'(v), 1);
        rdi("R4 short imm update", g * 8 + v % 8);
      end

    // wide modify and bit reversal (R5, R6)
    for (int g = 0; g < 2; g++)
      for (int t = 0; t < 5; t++) begin
        logic [31:0] iv;
        iv = (t == 0) ? 32'h0 : (t == 1) ? 32'h1 : (t == 2) ? 32'hFFFF_FFFF :
             (t == 3) ? 32'h8000_0000 : 32'hA512_3457;
        req("R5 modify", g, 2'b01, 0, 0, t, 0, iv, 1);
        rdi("R5 modify result", g * 8 + t);
        req("R6 bitrev", g, 2'b10, 0, 0, t + 1, 0, iv, 1);
        rdi("R6 bitrev result", g * 8 + t + 1);
      end

    // cancelled and empty requests (R7)
    for (int g = 0; g < 2; g++)
      for (int o = 0; o < 4; o++) begin
        req("R7 cancelled", g, 2'(o), 1, 0, 2, 3, 32'h0000_0111, 0);
        rdi("R7 cancelled state", g * 8 + 2);
        req("R7 op none", g, 2'b11, 1, 0, 2, 3, 32'h0000_0111, 1);
        rdi("R7 op none state", g * 8 + 2);
      end

    // write and update on the same index register (R9), and on different ones
    for (int g = 0; g < 2; g++) begin
      logic [31:0] upd;
      upd = (mi[g * 8 + 4] + mm[g * 8 + 1]) & msk(g);
      @(negedge clk);
      req_valid = 1; req_cond = 1; req_gen = 1'(g); req_op = 2'b00; req_post = 1;
      req_idx = 3'd4; req_mod = 3'd1;
      wr_en = 1; wr_kind = 0; wr_num = 4'(g * 8 + 4); wr_data = 32'h1234_5678;
      @(posedge clk); #1;
      idle();
      mi[g * 8 + 4] = upd;
      rdi("R9 update wins", g * 8 + 4);
      @(negedge clk);
      req_valid = 1; req_cond = 1; req_gen = 1'(g); req_op = 2'b01; req_idx = 3'd5;
      req_imm = 32'd7;
      wr_en = 1; wr_kind = 0; wr_num = 4'(g * 8 + 6); wr_data = 32'h0BAD_F00D;
      @(posedge clk); #1;
      idle();
      mi[g * 8 + 5] = (mi[g * 8 + 5] + 32'd7) & msk(g);
      mi[g * 8 + 6] = 32'h0BAD_F00D & msk(g);
      rdi("R9 distinct update", g * 8 + 5);
      rdi("R9 distinct write", g * 8 + 6);
    end

    repeat (2) @(posedge clk);
    #1 chk("R10 idle valid", {31'b0, addr_valid}, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule